// File: doc/BRIEF.md
# Signed Multiply-Accumulate with Addend Pre-Scaling

This datapath multiplies two signed 16-bit operands and combines the product with a 40-bit addend. Per operation it can add the product to the addend or take it away from the addend. Before that combination, the addend can pass through a fixed right shifter that scales it down by one bit or by sixteen bits. The shift is arithmetic, so the sign of the addend is kept.

The scaling lets one operation do two jobs. A 1-bit scale halves a running sum while the next product is folded in. A 16-bit scale moves the upper half of a wide accumulation down, which is the step a double-precision multiply needs before it adds the next partial product. The 40-bit width leaves eight guard bits above the 32-bit product to take up growth. Arithmetic wraps modulo 2^40.

One result is registered per valid strobe, with a latency of one cycle.

Top module: `scaled_mac`

## Requirements
- R1: When `subtract` is 0, the registered result equals the scaled addend plus the sign-extended 32-bit product, modulo 2^40.
- R2: When `subtract` is 1, the registered result equals the scaled addend minus the sign-extended product, modulo 2^40.
- R3: `shift_mode` = 2'b00 passes the addend through unscaled.
- R4: `shift_mode` = 2'b01 shifts the addend right by one bit, copying bit 39 into the top bit.
- R5: `shift_mode` = 2'b10 shifts the addend right by sixteen bits, copying bit 39 into bits 39..24.
- R6: `shift_mode` = 2'b11 is reserved and behaves exactly like 2'b00.
- R7: Both multiplier operands are two's complement. Two operands of -32768 give a product of +2^30.
- R8: `out_valid` is `in_valid` delayed by one clock. `acc_out` updates only on clocks where `in_valid` is 1 and otherwise holds its value.
- R9: While `rst` is high at a rising edge, `acc_out` is cleared to zero and `out_valid` to 0.
- R10: Overflow past bit 39 wraps with no saturation. For example, 0x7FFFFFFFFF + 0x3FFF0001 gives 0x803FFF0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_x | input | 16 | Signed multiplicand |
| op_y | input | 16 | Signed multiplier |
| acc_in | input | 40 | Addend, two's complement |
| subtract | input | 1 | 0 adds the product, 1 subtracts it |
| shift_mode | input | 2 | Addend scale: 00 none, 01 right 1, 10 right 16, 11 none |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| acc_out | output | 40 | Registered 40-bit result |

## Verification
The bound checker watches on every clock that the arithmetic result matches an independent signed-shift model. It also checks the one-cycle valid delay, that the result holds on idle clocks, the clearing by reset, and that the scaler output keeps the sign and treats the reserved code as a pass-through. The bench's scenarios cover what those per-cycle checks cannot show on their own:
- the exact wrap values at both ends of the 40-bit range;
- the -32768 by -32768 operand pair;
- a negative addend scaled by sixteen and then reduced;
- reset arriving on the same clock as a pending operation.

// File: rtl/scaled_mac_pkg.sv
package scaled_mac_pkg;

    localparam int unsigned OPND_W   = 16;
    localparam int unsigned ACCUM_W  = 40;
    localparam int unsigned SCALE_LO = 1;
    localparam int unsigned SCALE_HI = 16;

    typedef enum logic [1:0] {
        SCALE_NONE = 2'b00,
        SCALE_HALF = 2'b01,
        SCALE_WORD = 2'b10,
        SCALE_RSVD = 2'b11
    } scale_e;

    typedef enum logic {
        COMB_ADD = 1'b0,
        COMB_SUB = 1'b1
    } comb_e;

    // Operation presented to the combine stage
    typedef struct packed {
        logic [ACCUM_W-1:0] base;
        logic [ACCUM_W-1:0] prod;
        comb_e              mode;
    } comb_req_t;

    // Registered stage output
    typedef struct packed {
        logic               vld;
        logic [ACCUM_W-1:0] val;
    } comb_out_t;

    function automatic scale_e decode_scale(input logic [1:0] code);
        scale_e s;
        case (code)
            2'b01:   s = SCALE_HALF;
            2'b10:   s = SCALE_WORD;
            2'b11:   s = SCALE_RSVD;
            default: s = SCALE_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/scaled_mac_shift.sv
module scaled_mac_shift
    import scaled_mac_pkg::*;
#(
    parameter int unsigned W     = ACCUM_W,
    parameter int unsigned AMT_A = SCALE_LO,
    parameter int unsigned AMT_B = SCALE_HI
) (
    input  logic [W-1:0] din,
    input  scale_e       sel,
    output logic [W-1:0] dout
);
    localparam int unsigned SGN = W - 1;

    logic [W-1:0] by_a;
    logic [W-1:0] by_b;

    // Arithmetic shifts written as explicit sign replication
    assign by_a = {{AMT_A{din[SGN]}}, din[W-1:AMT_A]};
    assign by_b = {{AMT_B{din[SGN]}}, din[W-1:AMT_B]};

    always_comb begin
        unique case (sel)
            SCALE_HALF: dout = by_a;
            SCALE_WORD: dout = by_b;
            default:    dout = din;   // none and reserved
        endcase
    end
endmodule

// File: rtl/scaled_mac_mult.sv
module scaled_mac_mult
    import scaled_mac_pkg::*;
#(
    parameter int unsigned OPW = OPND_W,
    parameter int unsigned ACW = ACCUM_W
) (
    input  logic [OPW-1:0] x,
    input  logic [OPW-1:0] y,
    output logic [ACW-1:0] p_ext
);
    localparam int unsigned PW = 2 * OPW;

    logic signed [PW-1:0] prod;

    assign prod = $signed(x) * $signed(y);

    generate
        if (ACW > PW) begin : g_guard
            localparam int unsigned GW = ACW - PW;
            assign p_ext = {{GW{prod[PW-1]}}, prod};
        end else begin : g_trunc
            assign p_ext = prod[ACW-1:0];
        end
    endgenerate
endmodule

// File: rtl/scaled_mac_comb.sv
module scaled_mac_comb
    import scaled_mac_pkg::*;
#(
    parameter int unsigned ACW = ACCUM_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_vld,
    input  comb_req_t req,
    output comb_out_t q
);
    logic [ACW-1:0] nxt;

    // Modulo-2^ACW add or subtract; no saturation
    always_comb begin
        if (req.mode == COMB_SUB)
            nxt = req.base - req.prod;
        else
            nxt = req.base + req.prod;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.vld <= 1'b0;
            q.val <= '0;
        end else begin
            q.vld <= req_vld;
            if (req_vld)
                q.val <= nxt;
        end
    end
endmodule

// File: rtl/scaled_mac.sv
module scaled_mac
    import scaled_mac_pkg::*;
#(
    parameter int unsigned OP_W  = OPND_W,
    parameter int unsigned ACC_W = ACCUM_W,
    parameter int unsigned SH_A  = SCALE_LO,
    parameter int unsigned SH_B  = SCALE_HI
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_x,
    input  logic [OP_W-1:0]  op_y,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             subtract,
    input  logic [1:0]       shift_mode,
    output logic             out_valid,
    output logic [ACC_W-1:0] acc_out
);
    scale_e           scale_sel;
    logic [ACC_W-1:0] addend_sh;
    logic [ACC_W-1:0] prod_ext;
    comb_req_t        creq;
    comb_out_t        cout;

    assign scale_sel = decode_scale(shift_mode);

    scaled_mac_shift #(.W(ACC_W), .AMT_A(SH_A), .AMT_B(SH_B)) u_shift (
        .din  (acc_in),
        .sel  (scale_sel),
        .dout (addend_sh)
    );

    scaled_mac_mult #(.OPW(OP_W), .ACW(ACC_W)) u_mult (
        .x     (op_x),
        .y     (op_y),
        .p_ext (prod_ext)
    );

    assign creq.base = addend_sh;
    assign creq.prod = prod_ext;
    assign creq.mode = subtract ? COMB_SUB : COMB_ADD;

    scaled_mac_comb #(.ACW(ACC_W)) u_comb (
        .clk     (clk),
        .rst     (rst),
        .req_vld (in_valid),
        .req     (creq),
        .q       (cout)
    );

    assign out_valid = cout.vld;
    assign acc_out   = cout.val;
endmodule

// File: rtl/scaled_mac_chk.sv
module scaled_mac_chk #(
    parameter int unsigned OP_W  = 16,
    parameter int unsigned ACC_W = 40,
    parameter int unsigned SH_A  = 1,
    parameter int unsigned SH_B  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OP_W-1:0]  op_x,
    input logic [OP_W-1:0]  op_y,
    input logic [ACC_W-1:0] acc_in,
    input logic             subtract,
    input logic [1:0]       shift_mode,
    input logic             out_valid,
    input logic [ACC_W-1:0] acc_out,
    input logic [ACC_W-1:0] addend_sh
);
    function automatic logic [ACC_W-1:0] model(
        input logic [OP_W-1:0]  a,
        input logic [OP_W-1:0]  b,
        input logic [ACC_W-1:0] d,
        input logic             s,
        input logic [1:0]       m
    );
        logic signed [ACC_W-1:0] sd;
        logic signed [ACC_W-1:0] ea;
        logic signed [ACC_W-1:0] eb;
        logic signed [ACC_W-1:0] pr;
        sd = $signed(d);
        if (m == 2'b01)      sd = sd >>> SH_A;
        else if (m == 2'b10) sd = sd >>> SH_B;
        ea = $signed(a);
        eb = $signed(b);
        pr = ea * eb;
        return s ? (sd - pr) : (sd + pr);
    endfunction

    // R1 R2 R3 R4 R5 R7 R10
    sum_match_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid)) |->
            acc_out == model($past(op_x), $past(op_y), $past(acc_in),
                             $past(subtract), $past(shift_mode)));

    // R8
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(acc_out));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc_out == '0 && !out_valid));

    // R6
    rsvd_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_mode == 2'b11) |-> addend_sh == acc_in);

    // R5
    word_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_mode == 2'b10) |->
            ($countones(addend_sh[ACC_W-1 -: SH_B+1]) == (acc_in[ACC_W-1] ? SH_B+1 : 0)));
endmodule

bind scaled_mac scaled_mac_chk #(
    .OP_W(OP_W), .ACC_W(ACC_W), .SH_A(SH_A), .SH_B(SH_B)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_x       (op_x),
    .op_y       (op_y),
    .acc_in     (acc_in),
    .subtract   (subtract),
    .shift_mode (shift_mode),
    .out_valid  (out_valid),
    .acc_out    (acc_out),
    .addend_sh  (addend_sh)
);

// File: tb/sim_scaled_mac.sv
module sim_scaled_mac;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] op_x, op_y;
    logic [39:0] acc_in;
    logic        subtract;
    logic [1:0]  shift_mode;
    logic        out_valid;
    logic [39:0] acc_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    scaled_mac u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_x(op_x), .op_y(op_y),
        .acc_in(acc_in), .subtract(subtract), .shift_mode(shift_mode),
        .out_valid(out_valid), .acc_out(acc_out)
    );

    // {x[16], y[16], addend[40], sub[1], shift[2], expected[40]}
    localparam int NV = 15;
    localparam logic [114:0] VEC [NV] = '{
        {16'h0003, 16'h0004, 40'h0000000064, 1'b0, 2'b00, 40'h0000000070},
        {16'h0003, 16'h0004, 40'h0000000064, 1'b1, 2'b00, 40'h0000000058},
        {16'hFFFE, 16'h0005, 40'h0000000000, 1'b0, 2'b00, 40'hFFFFFFFFF6},
        {16'hFFFE, 16'hFFFD, 40'h0000000000, 1'b1, 2'b00, 40'hFFFFFFFFFA},
        {16'h0001, 16'h0001, 40'h0000000101, 1'b0, 2'b01, 40'h0000000081},
        {16'h0000, 16'h0000, 40'hFFFFFFFFFF, 1'b0, 2'b01, 40'hFFFFFFFFFF},
        {16'h0000, 16'h0000, 40'h8000000000, 1'b0, 2'b01, 40'hC000000000},
        {16'h0002, 16'h0008, 40'h0012340000, 1'b0, 2'b10, 40'h0000001244},
        {16'h0000, 16'h0007, 40'hF000000000, 1'b0, 2'b10, 40'hFFFFF00000},
        {16'h8000, 16'h8000, 40'h0000000000, 1'b0, 2'b00, 40'h0040000000},
        {16'h8000, 16'h8000, 40'h0000000000, 1'b1, 2'b00, 40'hFFC0000000},
        {16'h0001, 16'h0002, 40'h0000000100, 1'b0, 2'b11, 40'h0000000102},
        {16'h7FFF, 16'h7FFF, 40'h7FFFFFFFFF, 1'b0, 2'b00, 40'h803FFF0000},
        {16'h0001, 16'h0001, 40'h8000000000, 1'b1, 2'b10, 40'hFFFF7FFFFF},
        {16'h0001, 16'h0001, 40'h8000000000, 1'b1, 2'b00, 40'h7FFFFFFFFF}
    };

    function automatic string tag_of(int i);
        case (i)
            0:        return "R1";
            1:        return "R2";
            2, 3:     return "R3";
            4, 5, 6:  return "R4";
            7, 8, 13: return "R5";
            9, 10:    return "R7";
            11:       return "R6";
            default:  return "R10";
        endcase
    endfunction

    function automatic logic [39:0] ref_mac(logic [15:0] a, logic [15:0] b,
                                            logic [39:0] d, logic s, logic [1:0] m);
        logic signed [39:0] sd, ea, eb, pr;
        sd = $signed(d);
        if (m == 2'b01)      sd = sd >>> 1;
        else if (m == 2'b10) sd = sd >>> 16;
        ea = $signed(a);
        eb = $signed(b);
        pr = ea * eb;
        return s ? sd - pr : sd + pr;
    endfunction

    task automatic check(string req, logic [39:0] act, logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [15:0] a, logic [15:0] b,
                         logic [39:0] d, logic s, logic [1:0] m);
        in_valid = v; op_x = a; op_y = b; acc_in = d; subtract = s; shift_mode = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [39:0] hold_val;
        logic [31:0] lfsr;
        rst = 1'b1; in_valid = 1'b0; op_x = '0; op_y = '0;
        acc_in = '0; subtract = 1'b0; shift_mode = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9", acc_out, 40'h0);
        check("R9", {39'h0, out_valid}, 40'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i][114:99], VEC[i][98:83], VEC[i][82:43],
                  VEC[i][42], VEC[i][41:40]);
            check(tag_of(i), acc_out, VEC[i][39:0]);
            check("R8", {39'h0, out_valid}, 40'h1);
        end

        // R8: idle cycle holds result and drops valid
        hold_val = acc_out;
        drive(1'b0, 16'h1234, 16'h5678, 40'h00ABCDEF01, 1'b1, 2'b10);
        check("R8", acc_out, hold_val);
        check("R8", {39'h0, out_valid}, 40'h0);

        // R6 against R3: reserved code identical to no-shift, negative addend
        drive(1'b1, 16'h0010, 16'hFFF0, 40'hF123456789, 1'b0, 2'b11);
        check("R6", acc_out, ref_mac(16'h0010, 16'hFFF0, 40'hF123456789, 1'b0, 2'b00));

        // Model sweep across all scale codes and both combine modes (R1 R2 R4 R5)
        lfsr = 32'hACE1_2468;
        for (int k = 0; k < 64; k++) begin
            logic [15:0] a, b;
            logic [39:0] d;
            logic        s;
            logic [1:0]  m;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr[15:0];
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = lfsr[31:16];
            d = {lfsr[7:0], lfsr ^ 32'h5A5A_C3C3};
            s = k[0];
            m = k[2:1];
            drive(1'b1, a, b, d, s, m);
            check(s ? "R2" : "R1", acc_out, ref_mac(a, b, d, s, m));
        end

        // R9: reset on the same clock as a valid operation
        rst = 1'b1;
        drive(1'b1, 16'h0100, 16'h0100, 40'h1111111111, 1'b0, 2'b00);
        check("R9", acc_out, 40'h0);
        check("R9", {39'h0, out_valid}, 40'h0);
        rst = 1'b0;
        drive(1'b0, 16'h0, 16'h0, 40'h0, 1'b0, 2'b00);
        check("R8", {39'h0, out_valid}, 40'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule